// File: doc/BRIEF.md
# Proportional-Integral Loop Filter

This block is the loop filter of a carrier-tracking loop. The phase detector hands it one signed error sample per valid cycle. It returns a control word that steers the local oscillator. The control word has two parts. The first is the error scaled by a proportional gain. The second is a running sum of the error scaled by an integral gain. Both gains are signed run-time inputs read as fractions of 2^16, so firmware or a test harness can retune the loop while it runs.

Both combiners in the filter are adders only. To get a negative loop gain, the user supplies a negative gain word. The integral sum lives in a register, and that register is the one-sample delay of the integrator. Each output therefore pairs the current proportional term with the sum of all previous integral terms.

The integrator saturates at its own width, so it cannot wind up past a known limit and cannot wrap. The output word is clamped to the 16-bit signed range. A synchronous clear empties the integrator without disturbing the rest of the block.

Top module: `pi_loop_filter`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `ctl_valid` is 0, `ctl_data` is 0 and the integral sum is 0.
- R2: For a valid sample, the proportional term is floor(`kp`·`err_data` / 2^16), using arithmetic rounding toward minus infinity. `ctl_data` shows this term plus the stored integral sum on the cycle after the sample.
- R3: Each valid sample adds floor(`ki`·`err_data` / 2^16) to the integral sum. The output for a sample uses the sum as it stood before that sample, so a constant error yields a linear ramp that starts at the proportional term alone.
- R4: With `ki` = 0 the integral sum does not change, and the output is the proportional term alone, sample after sample.
- R5: There is no subtraction anywhere in the path. A negative `kp` (for example 0xC000 = -0.25) gives the negated output of the same positive gain.
- R6: `ctl_valid` equals `err_valid` delayed by one cycle. On cycles with `err_valid` low, both `ctl_data` and the integral sum hold their values.
- R7: `ctl_data` saturates at 32767 and -32768 instead of wrapping.
- R8: The integral sum is 24 bits and saturates at 8388607 and -8388608. A long run of positive error therefore leaves it at the upper rail, and it recovers in a bounded number of opposite samples.
- R9: `clr` high sets the integral sum to 0 on the next cycle. It takes priority over an update in the same cycle and does not change `ctl_data` or `ctl_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of the integral sum |
| err_valid | input | 1 | Error sample valid |
| err_data | input | 16 | Signed error sample |
| kp | input | 16 | Signed proportional gain, value / 2^16 |
| ki | input | 16 | Signed integral gain, value / 2^16 |
| ctl_valid | output | 1 | Control word valid |
| ctl_data | output | 16 | Signed saturated control word |

## Verification
Every result appears one clock after the sample that causes it, because the output register and the integrator register both capture on the same edge.

The bench drives inputs at the falling edge and reads the outputs at the next falling edge. Each read therefore sees exactly one rising edge after the sample it checks.

Expected values are built up sample by sample from R2 and R3. Sample n of a constant-error run should read the proportional term plus n integral terms.

Integrator saturation cannot be seen directly, because the output is clamped. It is shown through recovery time instead: after a long positive run, the bench counts how many negative samples pass before the output leaves the upper rail.

// File: rtl/pi_loop_pkg.sv
package pi_loop_pkg;
  // Widths shared by the filter and its bench-side checker
  localparam int unsigned ERR_W  = 16;
  localparam int unsigned GAIN_W = 16;
  localparam int unsigned FRAC_W = 16;
  localparam int unsigned ACC_W  = 24;
  localparam int unsigned OUT_W  = 16;

  // Index of each gain path in the scaled-term array
  typedef enum logic {PATH_P = 1'b0, PATH_I = 1'b1} path_e;
endpackage

// File: rtl/pi_gain_mult.sv
// Scales one error sample by a fractional gain: full product, then
// arithmetic shift right by FRAC (rounds toward minus infinity).
module pi_gain_mult #(
  parameter int unsigned DW   = 16,
  parameter int unsigned GW   = 16,
  parameter int unsigned FRAC = 16,
  localparam int unsigned MW  = DW + GW,
  localparam int unsigned SW  = MW - FRAC
) (
  input  logic signed [DW-1:0] x,
  input  logic signed [GW-1:0] g,
  output logic signed [SW-1:0] y
);
  logic signed [MW-1:0] prod;
  logic signed [MW-1:0] shifted;

  always_comb begin
    prod    = MW'(x) * MW'(g);
    shifted = prod >>> FRAC;
    y       = shifted[SW-1:0];
  end
endmodule

// File: rtl/pi_integrator.sv
// Registered, saturating accumulator. The register is the one-sample
// delay of the integral path.
module pi_integrator #(
  parameter int unsigned AW = 24,
  parameter int unsigned IW = 16,
  localparam int unsigned SW = AW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [IW-1:0] inc,
  output logic signed [AW-1:0] acc
);
  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] hi_lim;
  logic signed [SW-1:0] lo_lim;
  logic signed [AW-1:0] nxt;

  assign hi_lim = {2'b00, {(AW-1){1'b1}}};
  assign lo_lim = {2'b11, {(AW-1){1'b0}}};

  always_comb begin
    sum = SW'(acc) + SW'(inc);
    if (sum > hi_lim)      nxt = hi_lim[AW-1:0];
    else if (sum < lo_lim) nxt = lo_lim[AW-1:0];
    else                   nxt = sum[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= nxt;
  end
endmodule

// File: rtl/pi_out_stage.sv
// Adds the proportional term to the stored integral sum, clamps the
// result to the output width and registers it along with its valid flag.
module pi_out_stage #(
  parameter int unsigned AW = 24,
  parameter int unsigned PW = 16,
  parameter int unsigned OW = 16,
  localparam int unsigned SW = ((AW > PW) ? AW : PW) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [PW-1:0] p_term,
  input  logic signed [AW-1:0] acc,
  output logic                 y_valid,
  output logic signed [OW-1:0] y
);
  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] hi_lim;
  logic signed [SW-1:0] lo_lim;
  logic signed [OW-1:0] clamped;

  assign hi_lim = {{(SW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  assign lo_lim = {{(SW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  always_comb begin
    sum = SW'(p_term) + SW'(acc);
    if (sum > hi_lim)      clamped = hi_lim[OW-1:0];
    else if (sum < lo_lim) clamped = lo_lim[OW-1:0];
    else                   clamped = sum[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_valid <= 1'b0;
      y       <= '0;
    end else begin
      y_valid <= en;
      if (en) y <= clamped;
    end
  end
endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
  import pi_loop_pkg::*;
#(
  parameter int unsigned EW   = ERR_W,
  parameter int unsigned GW   = GAIN_W,
  parameter int unsigned FRAC = FRAC_W,
  parameter int unsigned AW   = ACC_W,
  parameter int unsigned OW   = OUT_W,
  localparam int unsigned TW  = EW + GW - FRAC
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 err_valid,
  input  logic signed [EW-1:0] err_data,
  input  logic signed [GW-1:0] kp,
  input  logic signed [GW-1:0] ki,
  output logic                 ctl_valid,
  output logic signed [OW-1:0] ctl_data
);
  logic signed [GW-1:0] gain_sel [2];
  logic signed [TW-1:0] term     [2];
  logic signed [AW-1:0] acc_q;

  assign gain_sel[PATH_P] = kp;
  assign gain_sel[PATH_I] = ki;

  // One scaler per gain path
  for (genvar k = 0; k < 2; k++) begin : g_path
    pi_gain_mult #(.DW(EW), .GW(GW), .FRAC(FRAC)) u_mult (
      .x(err_data),
      .g(gain_sel[k]),
      .y(term[k])
    );
  end

  pi_integrator #(.AW(AW), .IW(TW)) u_integ (
    .clk(clk),
    .rst(rst),
    .clr(clr),
    .en (err_valid),
    .inc(term[PATH_I]),
    .acc(acc_q)
  );

  pi_out_stage #(.AW(AW), .PW(TW), .OW(OW)) u_out (
    .clk    (clk),
    .rst    (rst),
    .en     (err_valid),
    .p_term (term[PATH_P]),
    .acc    (acc_q),
    .y_valid(ctl_valid),
    .y      (ctl_data)
  );
endmodule

// File: rtl/pi_loop_filter_chk.sv
module pi_loop_filter_chk #(
  parameter int unsigned GW = 16,
  parameter int unsigned OW = 16,
  parameter int unsigned AW = 24
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 clr,
  input logic                 err_valid,
  input logic signed [GW-1:0] ki,
  input logic                 ctl_valid,
  input logic signed [OW-1:0] ctl_data,
  input logic signed [AW-1:0] acc
);
  logic seen_clk;
  always_ff @(posedge clk) seen_clk <= 1'b1;

  // R6: valid follows the sample flag by one cycle
  a_r6_valid_delay: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && !$past(rst)) |-> (ctl_valid == $past(err_valid)));

  // R6: output holds when no sample arrived
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (seen_clk && !$past(rst) && !$past(err_valid)) |-> $stable(ctl_data));

  // R4 / R6: integral sum frozen with zero gain or no sample
  a_r4_integ_frozen: assert property (@(posedge clk) disable iff (rst)
    (!clr && (ki == '0 || !err_valid)) |=> $stable(acc));

  // R9: clear empties the integrator on the next cycle
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc == '0));

  // R1: reset leaves outputs idle
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!ctl_valid && ctl_data == '0 && acc == '0));
endmodule

bind pi_loop_filter pi_loop_filter_chk #(.GW(GW), .OW(OW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .err_valid(err_valid),
  .ki       (ki),
  .ctl_valid(ctl_valid),
  .ctl_data (ctl_data),
  .acc      (acc_q)
);

// File: tb/tb_pi_loop_filter.sv
module tb_pi_loop_filter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic err_valid = 1'b0;
  logic signed [15:0] err_data = '0;
  logic signed [15:0] kp = '0;
  logic signed [15:0] ki = '0;
  logic ctl_valid;
  logic signed [15:0] ctl_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pi_loop_filter dut (
    .clk(clk), .rst(rst), .clr(clr), .err_valid(err_valid),
    .err_data(err_data), .kp(kp), .ki(ki),
    .ctl_valid(ctl_valid), .ctl_data(ctl_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus at a falling edge; return at the next one
  task automatic step(input bit v, input int e);
    err_valid = v;
    err_data  = 16'(e);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; clr = 1'b0; err_valid = 1'b1; err_data = 16'sd1000;
    kp = 16'sh4000; ki = 16'sh1000;
    repeat (3) @(negedge clk);
    rst = 1'b0; err_valid = 1'b0;
    kp = '0; ki = '0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 valid", int'(ctl_valid), 0);
    check("R1 data", int'(ctl_data), 0);
    @(negedge clk);
    check("R1 data after release", int'(ctl_data), 0);
  endtask

  task automatic t_prop();
    do_reset();
    kp = 16'sh4000; ki = '0;
    step(1, 1000); check("R2 step", int'(ctl_data), 250);
    check("R6 valid", int'(ctl_valid), 1);
    step(1, -3);   check("R2 floor", int'(ctl_data), -1);
    step(1, -1000); check("R2 negative err", int'(ctl_data), -250);
  endtask

  task automatic t_ki_zero();
    do_reset();
    kp = 16'sh2000; ki = '0;
    for (int n = 0; n < 5; n++) begin
      step(1, 800); check("R4 pure proportional", int'(ctl_data), 100);
    end
  endtask

  task automatic t_neg_gain();
    do_reset();
    kp = -16'sd16384; ki = '0;
    step(1, 1000);  check("R5 negative kp", int'(ctl_data), -250);
    step(1, -1000); check("R5 negative kp neg err", int'(ctl_data), 250);
  endtask

  task automatic t_ramp_gate_clear();
    do_reset();
    kp = '0; ki = 16'sh1000;
    for (int n = 0; n < 8; n++) begin
      step(1, 1000); check("R3 ramp", int'(ctl_data), 62 * n);
    end
    for (int n = 0; n < 3; n++) begin
      step(0, 5000);
      check("R6 idle valid", int'(ctl_valid), 0);
      check("R6 idle hold", int'(ctl_data), 434);
    end
    step(1, 1000); check("R6 integrator held", int'(ctl_data), 496);
    clr = 1'b1; step(0, 0); clr = 1'b0;
    check("R9 output unchanged", int'(ctl_data), 496);
    kp = 16'sh4000;
    step(1, 1000); check("R9 cleared sum", int'(ctl_data), 250);
    step(1, 1000); check("R9 ramp restarts", int'(ctl_data), 312);
  endtask

  task automatic t_out_sat();
    do_reset();
    kp = '0; ki = 16'sh7FFF;
    step(1, 32767); check("R7 pos 0", int'(ctl_data), 0);
    step(1, 32767); check("R7 pos 1", int'(ctl_data), 16383);
    step(1, 32767); check("R7 pos 2", int'(ctl_data), 32766);
    step(1, 32767); check("R7 pos rail", int'(ctl_data), 32767);
    do_reset();
    kp = '0; ki = 16'sh7FFF;
    step(1, -32768); check("R7 neg 0", int'(ctl_data), 0);
    step(1, -32768); check("R7 neg 1", int'(ctl_data), -16384);
    step(1, -32768); check("R7 neg 2", int'(ctl_data), -32768);
    step(1, -32768); check("R7 neg rail", int'(ctl_data), -32768);
  endtask

  task automatic t_integ_sat();
    do_reset();
    kp = '0; ki = 16'sh7FFF;
    for (int n = 0; n < 600; n++) step(1, 32767);
    // sum is now 8388607; each negative sample removes 16384
    for (int n = 0; n < 512; n++) begin
      step(1, -32768);
      if (n == 510) check("R8 recovery edge", int'(ctl_data), 32767);
      if (n == 511) check("R8 recovered", int'(ctl_data), 16383);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_prop();
    t_ki_zero();
    t_neg_gain();
    t_ramp_gate_clear();
    t_out_sat();
    t_integ_sat();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule